// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through first-level data cache and the second-level cache. Every store leaves the first-level cache here, whether it hit or missed there. A store is one 32-bit word with a 4-bit byte enable, addressed by word. Each slot of the buffer covers one 32-byte aligned block. A slot holds the block address, the 256 data bits and a 32-bit mask of the bytes written so far.

A store to a block that already has a waiting slot is folded into that slot, so only stores to new blocks use up capacity. The one exception is the oldest slot. It is always offered on the drain port, and it accepts no further bytes. A store to its block takes a new slot. Slots leave in arrival order through a valid/ready port toward the lower cache. When all four slots are taken and a store cannot be folded, the producer is held off. An empty flag lets a fence wait until every store has left.

Top module: `wbuf_merge_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `drain_valid` is 0 and `wr_ready` is 1.
- R2: An accepted store whose block has no waiting slot other than the oldest one takes a new slot, and occupancy rises by one. Its block address is the word address with the low 3 word-select bits removed. Byte lane b of the word is stored in byte position word_select*4+b of the block: data bits [8p+7:8p] and mask bit p. The slot's other mask bits are 0.
- R3: An accepted store to the block of a waiting slot that is not the oldest is folded into that slot, and occupancy does not change. Mask bits are ORed in, and enabled bytes overwrite any earlier value.
- R4: The slot offered on the drain port never takes on new bytes. A store to its block goes to a different slot, or it stalls.
- R5: Slots drain oldest first, one per cycle in which `drain_valid` and `drain_ready` are both 1.
- R6: Occupancy never exceeds four, and `full` is 1 exactly when four slots are taken. While the buffer is full, `wr_ready` is 0 unless the store can be folded into a slot other than the oldest. A store that can be folded is accepted even when the buffer is full.
- R7: In a cycle where a store takes a new slot and a drain completes, occupancy is unchanged.
- R8: `empty` is 1 exactly when no slot is taken, and `drain_valid` equals the inverse of `empty`.
- R9: Every accepted byte reaches the drain port exactly once, carrying the value of the last store to that byte before its slot drained. No byte is lost.
- R10: While `drain_valid` is 1 and `drain_ready` is 0, `drain_addr`, `drain_data` and `drain_mask` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted this cycle when high together with wr_valid |
| wr_waddr | input | WADDR_W | Word address of the store |
| wr_data | input | 32 | Store data |
| wr_be | input | 4 | Byte enables, bit b for byte lane b |
| drain_valid | output | 1 | Oldest slot offered to the lower cache |
| drain_ready | input | 1 | Lower cache takes the offered slot |
| drain_addr | output | WADDR_W-3 | Block address of the offered slot |
| drain_data | output | 256 | Block data of the offered slot |
| drain_mask | output | 32 | Written-byte mask of the offered slot |
| empty | output | 1 | No slot taken |
| full | output | 1 | All four slots taken |

## Verification
Directed sequences come first. A lone store shows where bytes are placed. Repeated stores to one younger block separate folding from allocation and show that later bytes overwrite earlier ones. A store to the block on the drain port shows that the oldest slot is refused new bytes. A full buffer offered both a new block and a foldable one shows that the stall depends on the match. A store that arrives in the same cycle as a drain checks how occupancy is counted. Long sweeps then draw addresses from six blocks with random byte enables and two levels of back-pressure. A reference queue in the bench predicts each `wr_ready`, flag and drained block, so lost, duplicated, misplaced or reordered bytes all show up as mismatches.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WB_WORD_BYTES = 4;
  localparam int WB_BLK_BYTES  = 32;
  localparam int WB_WORD_BITS  = 8 * WB_WORD_BYTES;
  localparam int WB_BLK_BITS   = 8 * WB_BLK_BYTES;
  localparam int WB_WSEL_W     = $clog2(WB_BLK_BYTES / WB_WORD_BYTES);

  typedef logic [WB_BLK_BYTES-1:0]  blk_mask_t;
  typedef logic [WB_BLK_BITS-1:0]   blk_data_t;
  typedef logic [WB_WORD_BITS-1:0]  word_t;
  typedef logic [WB_WORD_BYTES-1:0] be_t;
  typedef logic [WB_WSEL_W-1:0]     wsel_t;

  // Byte positions within the block touched by a store to word wsel.
  function automatic blk_mask_t lane_mask(input wsel_t wsel, input be_t be);
    blk_mask_t m;
    m = '0;
    for (int b = 0; b < WB_WORD_BYTES; b++)
      m[int'(wsel) * WB_WORD_BYTES + b] = be[b];
    return m;
  endfunction

  // The word copied into every word position of a block.
  function automatic blk_data_t spread_word(input word_t w);
    blk_data_t d;
    for (int i = 0; i < WB_BLK_BYTES / WB_WORD_BYTES; i++)
      d[i*WB_WORD_BITS +: WB_WORD_BITS] = w;
    return d;
  endfunction

  // Byte mask widened to a bit mask.
  function automatic blk_data_t byte_bits(input blk_mask_t m);
    blk_data_t d;
    for (int i = 0; i < WB_BLK_BYTES; i++)
      d[i*8 +: 8] = {8{m[i]}};
    return d;
  endfunction

  function automatic blk_data_t merge_bytes(input blk_data_t old, input word_t w,
                                            input blk_mask_t lm);
    blk_data_t bm;
    bm = byte_bits(lm);
    return (old & ~bm) | (spread_word(w) & bm);
  endfunction
endpackage

// File: rtl/wbuf_ptr_ctrl.sv
module wbuf_ptr_ctrl #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (int'(i) == DEPTH - 1) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (alloc) tail <= next_idx(tail);
      if (pop)   head <= next_idx(head);
      case ({alloc, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (int'(occ) == DEPTH);
  assign empty = (occ == '0);
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 27,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            ent_valid,
  input  logic [DEPTH-1:0][BLK_W-1:0] ent_blk,
  input  logic [IDX_W-1:0]            head,
  input  logic [BLK_W-1:0]            wr_blk,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [DEPTH-1:0] cand;

  // The oldest slot is always on offer downstream and is never a merge target.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign cand[g] = ent_valid[g] && (ent_blk[g] == wr_blk) && (int'(head) != g);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int BLK_W = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc,
  input  logic                     merge,
  input  logic                     pop,
  input  logic [BLK_W-1:0]         wr_blk,
  input  wbuf_pkg::wsel_t          wr_wsel,
  input  wbuf_pkg::word_t          wr_data,
  input  wbuf_pkg::be_t            wr_be,
  output logic                     valid,
  output logic [BLK_W-1:0]         blk,
  output wbuf_pkg::blk_data_t      data,
  output wbuf_pkg::blk_mask_t      mask
);
  import wbuf_pkg::*;

  blk_mask_t lm;
  assign lm = lane_mask(wr_wsel, wr_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      blk   <= '0;
      data  <= '0;
      mask  <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      blk   <= wr_blk;
      data  <= merge_bytes('0, wr_data, lm);
      mask  <= lm;
    end else if (merge) begin
      data  <= merge_bytes(data, wr_data, lm);
      mask  <= mask | lm;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wbuf_merge_top.sv
module wbuf_merge_top #(
  parameter int WADDR_W = 30,
  parameter int DEPTH   = 4,
  localparam int BLK_W  = WADDR_W - wbuf_pkg::WB_WSEL_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [WADDR_W-1:0]           wr_waddr,
  input  logic [wbuf_pkg::WB_WORD_BITS-1:0]  wr_data,
  input  logic [wbuf_pkg::WB_WORD_BYTES-1:0] wr_be,
  output logic                         drain_valid,
  input  logic                         drain_ready,
  output logic [BLK_W-1:0]             drain_addr,
  output logic [wbuf_pkg::WB_BLK_BITS-1:0]   drain_data,
  output logic [wbuf_pkg::WB_BLK_BYTES-1:0]  drain_mask,
  output logic                         empty,
  output logic                         full
);
  import wbuf_pkg::*;

  // Named internal events, observed by the bound checker.
  logic              wr_hit, wr_fire, alloc_fire, merge_fire, drain_fire;
  logic [IDX_W-1:0]  hit_idx, head, tail;
  logic [CNT_W-1:0]  occ;
  logic [BLK_W-1:0]  wr_blk;
  wsel_t             wr_wsel;

  logic [DEPTH-1:0]            ent_valid;
  logic [DEPTH-1:0][BLK_W-1:0] ent_blk;
  blk_data_t                   ent_data [DEPTH];
  blk_mask_t                   ent_mask [DEPTH];

  assign wr_blk  = wr_waddr[WADDR_W-1:WB_WSEL_W];
  assign wr_wsel = wr_waddr[WB_WSEL_W-1:0];

  wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) match_i (
    .ent_valid (ent_valid),
    .ent_blk   (ent_blk),
    .head      (head),
    .wr_blk    (wr_blk),
    .hit       (wr_hit),
    .hit_idx   (hit_idx)
  );

  assign wr_ready    = wr_hit || !full;
  assign wr_fire     = wr_valid && wr_ready;
  assign merge_fire  = wr_fire && wr_hit;
  assign alloc_fire  = wr_fire && !wr_hit;
  assign drain_valid = !empty;
  assign drain_fire  = drain_valid && drain_ready;

  wbuf_ptr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc_fire),
    .pop   (drain_fire),
    .head  (head),
    .tail  (tail),
    .occ   (occ),
    .full  (full),
    .empty (empty)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    wbuf_entry #(.BLK_W(BLK_W)) ent_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (alloc_fire && (int'(tail) == g)),
      .merge   (merge_fire && (int'(hit_idx) == g)),
      .pop     (drain_fire && (int'(head) == g)),
      .wr_blk  (wr_blk),
      .wr_wsel (wr_wsel),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .valid   (ent_valid[g]),
      .blk     (ent_blk[g]),
      .data    (ent_data[g]),
      .mask    (ent_mask[g])
    );
  end

  assign drain_addr = ent_blk[head];
  assign drain_data = ent_data[head];
  assign drain_mask = ent_mask[head];
endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 27,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_hit,
  input logic             drain_valid,
  input logic             drain_ready,
  input logic [BLK_W-1:0] drain_addr,
  input logic [255:0]     drain_data,
  input logic [31:0]      drain_mask,
  input logic             empty,
  input logic             full,
  input logic [CNT_W-1:0] occ
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_hit) |-> !wr_ready);

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_hit && !(drain_valid && drain_ready))
      |=> (occ == $past(occ) + 1'b1));

  // R3
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_hit && !(drain_valid && drain_ready))
      |=> (occ == $past(occ)));

  // R7
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_hit && drain_valid && drain_ready)
      |=> (occ == $past(occ)));

  // R8
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!drain_valid && !full));

  // R4 R10
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready)
      |=> (drain_valid && $stable(drain_addr) && $stable(drain_data) && $stable(drain_mask)));
endmodule

bind wbuf_merge_top wbuf_merge_chk #(.DEPTH(DEPTH), .BLK_W(BLK_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_hit      (wr_hit),
  .drain_valid (drain_valid),
  .drain_ready (drain_ready),
  .drain_addr  (drain_addr),
  .drain_data  (drain_data),
  .drain_mask  (drain_mask),
  .empty       (empty),
  .full        (full),
  .occ         (occ)
);

// File: tb/wbuf_merge_top_tb.sv
`timescale 1ns/1ps
module wbuf_merge_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [29:0]  wr_waddr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   wr_be = '0;
  logic         drain_valid;
  logic         drain_ready = 1'b0;
  logic [26:0]  drain_addr;
  logic [255:0] drain_data;
  logic [31:0]  drain_mask;
  logic         empty, full;

  always #2 clk = ~clk;

  wbuf_merge_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_waddr(wr_waddr), .wr_data(wr_data), .wr_be(wr_be),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_addr(drain_addr),
    .drain_data(drain_data), .drain_mask(drain_mask), .empty(empty), .full(full)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  // Reference queue, index 0 is the oldest slot.
  logic [26:0]  m_blk  [4];
  logic [255:0] m_data [4];
  logic [31:0]  m_mask [4];
  int m_cnt = 0;

  bit           hold_prev = 0;
  logic [26:0]  s_addr;
  logic [255:0] s_data;
  logic [31:0]  s_mask;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bytes(input int k, input logic [29:0] a, input logic [31:0] d,
                           input logic [3:0] be);
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        int p;
        p = int'(a[2:0]) * 4 + b;
        m_data[k][p*8 +: 8] = d[b*8 +: 8];
        m_mask[k][p] = 1'b1;
      end
    end
  endtask

  task automatic step(input bit v, input logic [29:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit dr);
    int hit_k, pre;
    bit exp_rdy;
    @(negedge clk);
    wr_valid = v; wr_waddr = a; wr_data = d; wr_be = be; drain_ready = dr;
    #1;
    pre = m_cnt;
    hit_k = -1;
    for (int i = 1; i < m_cnt; i++)
      if (m_blk[i] == a[29:3] && hit_k < 0) hit_k = i;
    exp_rdy = (hit_k >= 0) || (m_cnt < 4);
    // R8 flags, R6 full and stall rule
    chk(empty == (m_cnt == 0), "R8", 256'(empty), 256'(m_cnt == 0));
    chk(drain_valid == (m_cnt > 0), "R8", 256'(drain_valid), 256'(m_cnt > 0));
    chk(full == (m_cnt == 4), "R6", 256'(full), 256'(m_cnt == 4));
    chk(wr_ready == exp_rdy, (tag == "R1") ? "R1" : "R6", 256'(wr_ready), 256'(exp_rdy));
    if (m_cnt > 0) begin
      chk(drain_addr == m_blk[0], tag, 256'(drain_addr), 256'(m_blk[0]));
      chk(drain_mask == m_mask[0], tag, 256'(drain_mask), 256'(m_mask[0]));
      chk(drain_data == m_data[0], tag, drain_data, m_data[0]);
    end
    if (hold_prev) begin
      // R10 held offer
      chk(drain_addr == s_addr && drain_mask == s_mask && drain_data == s_data,
          "R10", drain_data, s_data);
    end
    hold_prev = (pre > 0) && !dr;
    s_addr = drain_addr; s_data = drain_data; s_mask = drain_mask;
    if (v && exp_rdy) begin
      if (hit_k >= 0) put_bytes(hit_k, a, d, be);
      else begin
        m_blk[m_cnt] = a[29:3]; m_data[m_cnt] = '0; m_mask[m_cnt] = '0;
        put_bytes(m_cnt, a, d, be);
        m_cnt++;
      end
    end
    if (pre > 0 && dr) begin
      for (int i = 0; i < 3; i++) begin
        m_blk[i] = m_blk[i+1]; m_data[i] = m_data[i+1]; m_mask[i] = m_mask[i+1];
      end
      m_cnt--;
    end
  endtask

  function automatic logic [29:0] wa(input int blk, input int w);
    return {27'(27'h40 + blk), 3'(w)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; step(0, '0, '0, '0, 0);
    tag = "R2"; step(1, wa(0, 3), 32'hA1B2C3D4, 4'b0101, 0); step(0, '0, '0, '0, 0);
    tag = "R3";
    step(1, wa(1, 0), 32'h11223344, 4'b1111, 0);
    step(1, wa(1, 0), 32'h5566EEFF, 4'b0011, 0);
    step(1, wa(1, 7), 32'h99000000, 4'b1000, 0);
    step(0, '0, '0, '0, 0);
    tag = "R4"; step(1, wa(0, 3), 32'hCAFE0000, 4'b1010, 0); step(0, '0, '0, '0, 0);
    tag = "R6";
    step(1, wa(2, 1), 32'h01020304, 4'b1111, 0);
    step(1, wa(3, 0), 32'hDEADBEEF, 4'b1111, 0);
    step(1, wa(1, 2), 32'h77777777, 4'b0110, 0);
    step(1, wa(0, 5), 32'h12345678, 4'b1111, 0);
    step(0, '0, '0, '0, 0);
    tag = "R7";
    step(0, '0, '0, '0, 1);
    step(1, wa(4, 6), 32'h0BADF00D, 4'b1111, 1);
    step(0, '0, '0, '0, 0);
    tag = "R5";
    for (int i = 0; i < 6; i++) step(0, '0, '0, '0, 1);
    tag = "R9";
    for (int ph = 0; ph < 2; ph++) begin
      for (int n = 0; n < 4000; n++) begin
        bit v, dr;
        v  = ($urandom_range(0, 9) < 7);
        dr = (ph == 0) ? ($urandom_range(0, 9) < 5) : ($urandom_range(0, 9) < 2);
        step(v, wa($urandom_range(0, 5), $urandom_range(0, 7)), $urandom(),
             4'($urandom_range(0, 15)), dr);
      end
    end
    tag = "R8";
    for (int i = 0; i < 8; i++) step(0, '0, '0, '0, 1);
    chk(empty == 1'b1, "R8", 256'(empty), 256'(1));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule